// File: doc/BRIEF.md
# Shared-Datapath Delta-Sigma Pulse-Density Pixel Driver

This block converts a raster stream of 24-bit RGB pixels into three 1-bit pulse-density streams, one per color channel, for a panel whose pixels are driven fully on or fully off. Each channel has a single first-order delta-sigma stage that is shared by every pixel in raster order. The integrator value of each pixel is held in a per-channel state memory. On every visit the block reads that value, adds the new gray level, and writes the result back. Because this state is never cleared between sub-fields, the pulse train of a pixel runs on without a break across frame boundaries. Its density over many sub-fields follows the gray level.

The pulse bits are packed into 64-bit column words, the first pixel of each word in bit 0. Each word is presented with a one-cycle load strobe and the index of the column chain that should shift it in. Four chains take words in turn. A sub-field start strobe realigns the block to the first pixel. A seed level sets the integrator value that each pixel starts from on its first visit after reset. This shifts the phase of the pulse train, which cancels the average error that a constant input would otherwise leave in a finite viewing window.

Top module: `pdm_pixel_driver`

## Requirements
- R1: For each channel c (R = channel 2 at pix_rgb[23:16], G = channel 1 at [15:8], B = channel 0 at [7:0]), an accepted pixel produces a pulse equal to the carry of the 9-bit sum of the pixel's stored 8-bit state and the 8-bit level. The low 8 bits of that sum become the pixel's new state.
- R2: Pixel state is kept across sub-field starts and raster wraps. It is never cleared except by reset.
- R3: After reset, col_load and col_words are 0. On its first visit after reset a pixel starts from seed_level. The value of seed_level at later visits has no effect.
- R4: A level of 0 always produces a 0 pulse, so an all-black image yields all-zero words.
- R5: For a constant level L held over N visits, the count of 1 pulses k of a pixel satisfies |256·k − N·L| ≤ 256.
- R6: Bit i of a channel's word in col_words[c*64 +: 64] is the pulse of the i-th pixel accepted since the word began. A word that collects 64 bits is presented with col_load high for one cycle, in the cycle after the edge that accepts its 64th pixel.
- R7: Accepting the last pixel of the raster (index H_PIX·V_PIX−1) ends the current word early. Its unused upper bits are 0.
- R8: col_chain gives the word's index within the raster modulo 4 (0,1,2,3,0,…). It restarts at 0 at each raster start.
- R9: sf_start makes the pixel accepted in that cycle (or the next one accepted) pixel index 0. It discards any partly filled word and restarts col_chain at 0.
- R10: Without sf_start, the pixel index wraps from the last pixel to 0.
- R11: A cycle with pix_valid low changes no state and raises no col_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_start | input | 1 | Sub-field start: restart at pixel index 0 |
| pix_valid | input | 1 | pix_rgb carries a pixel this cycle |
| pix_rgb | input | 24 | Gray levels R[23:16], G[15:8], B[7:0] |
| seed_level | input | 8 | Starting state for each pixel's first visit after reset |
| col_words | output | 192 | Packed words: B [63:0], G [127:64], R [191:128] |
| col_load | output | 1 | One-cycle strobe: col_words holds a completed word |
| col_chain | output | 2 | Column chain that takes the presented word |

## Verification
A pixel's pulse is fixed at the clock edge that accepts it. Its word appears on col_words, together with col_load and col_chain, one cycle after the edge that accepts the 64th or the raster's last pixel, and nothing is due at any other time. The bench drives each pixel on a falling edge and works out the expected word in a model of R1 at that moment. It queues the word before the accepting rising edge. A monitor samples on the following falling edge, so each strobe is compared in exactly the cycle it is due. An unexpected strobe or a word still queued at the end is a mismatch. Pulse densities are tallied from the compared words to check the sub-field averages.

// File: rtl/pdm_drv_pkg.sv
package pdm_drv_pkg;
    parameter int GRAY_W   = 8;
    parameter int CHANNELS = 3;
    parameter int WORD_W   = 64;
    parameter int CHAINS   = 4;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int CHAIN_W = (CHAINS > 1) ? $clog2(CHAINS) : 1;

    typedef logic [GRAY_W-1:0] gray_t;
endpackage

// File: rtl/pdm_dsm_cell.sv
module pdm_dsm_cell
    import pdm_drv_pkg::*;
(
    input  gray_t level,
    input  gray_t state,
    output logic  pulse,
    output gray_t next_state
);
    // First-order loop: quantizer is the carry of the single adder
    always_comb begin
        {pulse, next_state} = {1'b0, state} + {1'b0, level};
    end
endmodule

// File: rtl/pdm_state_mem.sv
module pdm_state_mem
    import pdm_drv_pkg::*;
#(
    parameter int DEPTH = 768,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gray_t         seed,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  gray_t         wr_data,
    output gray_t         rd_data
);
    gray_t            mem_q [DEPTH];
    logic [DEPTH-1:0] seen_d, seen_q;

    // An entry never written since reset reads as the seed
    assign rd_data = seen_q[addr] ? mem_q[addr] : seed;

    always_comb begin
        seen_d = seen_q;
        if (wr_en) seen_d[addr] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wr_data;
    end
endmodule

// File: rtl/pdm_word_packer.sv
module pdm_word_packer
    import pdm_drv_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              restart,
    input  logic                              bit_valid,
    input  logic                              last,
    input  logic [CHANNELS-1:0]               bits,
    output logic [CHANNELS-1:0][WORD_W-1:0]   words,
    output logic                              load,
    output logic [CHAIN_W-1:0]                chain
);
    typedef struct packed {
        logic [CHANNELS-1:0][WORD_W-1:0] acc;
        logic [CHANNELS-1:0][WORD_W-1:0] word;
        logic [IDX_W-1:0]                idx;
        logic [CHAIN_W-1:0]              chain;
        logic [CHAIN_W-1:0]              word_chain;
        logic                            load;
    } pack_t;

    pack_t pk_d, pk_q;
    logic [CHANNELS-1:0][WORD_W-1:0] acc_n;

    always_comb begin
        pk_d      = pk_q;
        pk_d.load = 1'b0;
        if (restart) begin
            pk_d.acc   = '0;
            pk_d.idx   = '0;
            pk_d.chain = '0;
        end
        for (int c = 0; c < CHANNELS; c++) begin
            acc_n[c] = pk_d.acc[c] | (WORD_W'(bits[c]) << pk_d.idx);
        end
        if (bit_valid) begin
            if (pk_d.idx == IDX_W'(WORD_W - 1) || last) begin
                pk_d.word       = acc_n;
                pk_d.word_chain = pk_d.chain;
                pk_d.load       = 1'b1;
                pk_d.acc        = '0;
                pk_d.idx        = '0;
                if (last || pk_d.chain == CHAIN_W'(CHAINS - 1)) pk_d.chain = '0;
                else                                             pk_d.chain = pk_d.chain + 1'b1;
            end else begin
                pk_d.acc = acc_n;
                pk_d.idx = pk_d.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign words = pk_q.word;
    assign load  = pk_q.load;
    assign chain = pk_q.word_chain;
endmodule

// File: rtl/pdm_pixel_driver.sv
module pdm_pixel_driver
    import pdm_drv_pkg::*;
#(
    parameter int H_PIX = 32,
    parameter int V_PIX = 24,
    localparam int DEPTH = H_PIX * V_PIX,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sf_start,
    input  logic                          pix_valid,
    input  logic [CHANNELS*GRAY_W-1:0]    pix_rgb,
    input  logic [GRAY_W-1:0]             seed_level,
    output logic [CHANNELS*WORD_W-1:0]    col_words,
    output logic                          col_load,
    output logic [CHAIN_W-1:0]            col_chain
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } scan_t;

    scan_t scan_d, scan_q;
    logic [AW-1:0] cur_addr;
    logic          cur_last;
    logic [AW-1:0] pix_addr;

    logic [CHANNELS-1:0]             pulses;
    gray_t [CHANNELS-1:0]            st_rd;
    gray_t [CHANNELS-1:0]            st_wr;
    logic [CHANNELS-1:0][WORD_W-1:0] words;

    always_comb begin
        scan_d   = scan_q;
        cur_addr = sf_start ? '0 : scan_q.addr;
        cur_last = (cur_addr == AW'(DEPTH - 1));
        scan_d.addr = cur_addr;
        if (pix_valid) scan_d.addr = cur_last ? '0 : cur_addr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign pix_addr = scan_q.addr;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        pdm_state_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .seed    (seed_level),
            .addr    (cur_addr),
            .wr_en   (pix_valid),
            .wr_data (st_wr[c]),
            .rd_data (st_rd[c])
        );
        pdm_dsm_cell u_cell (
            .level      (pix_rgb[c*GRAY_W +: GRAY_W]),
            .state      (st_rd[c]),
            .pulse      (pulses[c]),
            .next_state (st_wr[c])
        );
    end

    pdm_word_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (sf_start),
        .bit_valid (pix_valid),
        .last      (cur_last),
        .bits      (pulses),
        .words     (words),
        .load      (col_load),
        .chain     (col_chain)
    );

    assign col_words = words;
endmodule

// File: rtl/pdm_pixel_driver_chk.sv
module pdm_pixel_driver_chk
    import pdm_drv_pkg::*;
#(
    parameter int DEPTH = 768,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sf_start,
    input logic                       pix_valid,
    input logic                       col_load,
    input logic [AW-1:0]              pix_addr,
    input logic [CHANNELS*GRAY_W-1:0] pix_rgb,
    input logic [CHANNELS-1:0]        pulses,
    input gray_t [CHANNELS-1:0]       st_rd,
    input gray_t [CHANNELS-1:0]       st_wr
);
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_addr < AW'(DEPTH)); // R10

    AST_SF_IDLE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start && !pix_valid |=> pix_addr == '0); // R9

    AST_SF_PIXEL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start && pix_valid |=> pix_addr == AW'(1)); // R9

    AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_start && !pix_valid |=> $stable(pix_addr)); // R11

    AST_LOAD_AFTER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        col_load |-> $past(pix_valid)); // R6

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
        AST_BLACK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid && pix_rgb[c*GRAY_W +: GRAY_W] == '0 |-> !pulses[c]); // R4
        AST_PULSE_WRAPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid && pulses[c] |-> st_wr[c] < st_rd[c]); // R1
        AST_NO_PULSE_GROWS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid && !pulses[c] |-> st_wr[c] >= st_rd[c]); // R1
    end
endmodule

bind pdm_pixel_driver pdm_pixel_driver_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sf_start  (sf_start),
    .pix_valid (pix_valid),
    .col_load  (col_load),
    .pix_addr  (pix_addr),
    .pix_rgb   (pix_rgb),
    .pulses    (pulses),
    .st_rd     (st_rd),
    .st_wr     (st_wr)
);

// File: tb/pdm_pixel_driver_test.sv
`timescale 1ns/1ps
module pdm_pixel_driver_test;
    localparam int HP = 20;
    localparam int VP = 15;
    localparam int NPIX = HP * VP;
    localparam int NSF = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sf_start = 1'b0;
    logic         pix_valid = 1'b0;
    logic [23:0]  pix_rgb = '0;
    logic [7:0]   seed_level = '0;
    logic [191:0] col_words;
    logic         col_load;
    logic [1:0]   col_chain;

    pdm_pixel_driver #(.H_PIX(HP), .V_PIX(VP)) uut (
        .clk(clk), .rst_n(rst_n), .sf_start(sf_start), .pix_valid(pix_valid),
        .pix_rgb(pix_rgb), .seed_level(seed_level), .col_words(col_words),
        .col_load(col_load), .col_chain(col_chain)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [191:0] words;
        logic [1:0]   chain;
        int           base;
        int           nbits;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Requirement model state
    int          m_st [3][NPIX];
    bit          m_vld [NPIX];
    logic [63:0] m_acc [3];
    int          m_addr, m_idx, m_chain, m_wbase;
    string       cur_tag;
    bit          cnt_en = 1'b0;
    int          ones [3][NPIX];
    int          black_img = 0;

    function automatic logic [7:0] level_of(int a, int c, int ph);
        if (black_img != 0) return 8'd0;
        if (a % 10 == 0) return 8'd0;
        if (a % 17 == 5) return 8'd255;
        return 8'((a * 37 + c * 91 + ph * 13) % 256);
    endfunction

    task automatic model_clear();
        for (int a = 0; a < NPIX; a++) m_vld[a] = 1'b0;
        for (int c = 0; c < 3; c++) m_acc[c] = '0;
        m_addr = 0; m_idx = 0; m_chain = 0; m_wbase = 0;
    endtask

    task automatic check(bit ok, string what, logic [191:0] got, logic [191:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic drive_pix(bit sf, int ph);
        logic [23:0] rgb;
        int s;
        @(negedge clk);
        if (sf) begin
            m_addr = 0; m_idx = 0; m_chain = 0; m_wbase = 0;
            for (int c = 0; c < 3; c++) m_acc[c] = '0;
        end
        for (int c = 0; c < 3; c++) rgb[c*8 +: 8] = level_of(m_addr, c, ph);
        sf_start = sf; pix_valid = 1'b1; pix_rgb = rgb;
        if (m_idx == 0) m_wbase = m_addr;
        for (int c = 0; c < 3; c++) begin
            s = (m_vld[m_addr] ? m_st[c][m_addr] : int'(seed_level)) + int'(rgb[c*8 +: 8]);
            m_st[c][m_addr] = s % 256;
            m_acc[c][m_idx] = (s >= 256);
        end
        m_vld[m_addr] = 1'b1;
        if (m_idx == 63 || m_addr == NPIX - 1) begin
            exp_t e;
            e.words = {m_acc[2], m_acc[1], m_acc[0]};
            e.chain = 2'(m_chain);
            e.base  = m_wbase;
            e.nbits = m_idx + 1;
            e.tag   = (m_addr == NPIX - 1 && m_idx != 63) ? {cur_tag, "/R7"} : cur_tag;
            exp_q.push_back(e);
            for (int c = 0; c < 3; c++) m_acc[c] = '0;
            m_idx = 0;
            m_chain = (m_addr == NPIX - 1) ? 0 : (m_chain + 1) % 4;
        end else begin
            m_idx++;
        end
        m_addr = (m_addr == NPIX - 1) ? 0 : m_addr + 1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sf_start = 1'b0; pix_valid = 1'b0;
        end
    endtask

    task automatic run_subfield(bit sf, int ph, int gap);
        for (int i = 0; i < NPIX; i++) begin
            drive_pix(sf && i == 0, ph);
            if (gap > 0 && i % gap == gap - 1) idle(1);
        end
    endtask

    // Monitor: compares each strobe in the cycle it is due
    always @(negedge clk) begin
        if (rst_n && col_load) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11/R6 unexpected col_load", col_words, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(col_words == e.words, {e.tag, "/R1/R6 word"}, col_words, e.words);
                check(col_chain == e.chain, {e.tag, "/R8 chain"}, 192'(col_chain), 192'(e.chain));
                if (cnt_en)
                    for (int c = 0; c < 3; c++)
                        for (int i = 0; i < e.nbits; i++)
                            ones[c][e.base + i] += int'(col_words[c*64 + i]);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_clear();
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        // R3: reset state at the ports
        check(col_load == 1'b0, "R3 reset col_load", 192'(col_load), '0);
        check(col_words == '0, "R3 reset col_words", col_words, '0);
        rst_n = 1'b1;
        idle(2);

        // R1/R11: mixed levels with idle gaps
        cur_tag = "R11";
        run_subfield(1'b1, 0, 7);
        idle(3);

        // R2/R5/R10: constant image over NSF sub-fields, sf_start only on even ones
        cur_tag = "R2";
        for (int c = 0; c < 3; c++) for (int a = 0; a < NPIX; a++) ones[c][a] = 0;
        idle(2);
        cnt_en = 1'b1;
        for (int f = 0; f < NSF; f++) begin
            cur_tag = (f % 2 == 1) ? "R10" : "R2";
            run_subfield(f % 2 == 0, 1, 0);
        end
        idle(3);
        cnt_en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            for (int a = 0; a < NPIX; a++) begin
                int err;
                err = 256 * ones[c][a] - NSF * int'(level_of(a, c, 1));
                if (err < 0) err = -err;
                check(err <= 256, "R5 average density", 192'(ones[c][a] * 256), 192'(NSF * int'(level_of(a, c, 1))));
            end
        end

        // R9: sf_start in mid-raster drops the partial word
        cur_tag = "R9";
        for (int i = 0; i < 100; i++) drive_pix(1'b0, 2);
        idle(1);
        @(negedge clk);
        sf_start = 1'b1; pix_valid = 1'b0;
        m_addr = 0; m_idx = 0; m_chain = 0;
        for (int c = 0; c < 3; c++) m_acc[c] = '0;
        run_subfield(1'b0, 2, 11);
        idle(3);

        // R4: black image gives all-zero words
        cur_tag = "R4";
        black_img = 1;
        run_subfield(1'b1, 3, 0);
        run_subfield(1'b1, 3, 0);
        black_img = 0;
        idle(3);

        // R3: second reset with a non-zero seed, later seed changes ignored
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        seed_level = 8'd200;
        idle(2);
        check(col_load == 1'b0, "R3 reset col_load again", 192'(col_load), '0);
        rst_n = 1'b1;
        idle(1);
        cur_tag = "R3";
        run_subfield(1'b1, 4, 5);
        seed_level = 8'd7;
        run_subfield(1'b1, 4, 0);
        idle(4);

        check(exp_q.size() == 0, "R6 words still pending", 192'(exp_q.size()), '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule